// File: doc/BRIEF.md
# Bus-Mapped JTAG Bit-Bang Port

This block lets a processor drive a JTAG scan chain through one location on its existing parallel bus, so no general-purpose pins are spent on the chain. Software writes a nibble to the mapped address. Three of its bits set the test-data-in, test-mode-select and test-clock lines. Software produces each chain clock pulse with two writes: one raising the clock and one lowering it. The chain's test-data-out line is brought onto the bus through a two-stage synchronizer and read back at the same address.

The three drive bits are held in registers. All three lines therefore change together on one system-clock edge. A select input hands the chain pins to an external download-cable header instead of the registers. While the cable owns the pins, the registers keep taking writes, and their contents stay readable for diagnostics.

Top module: `jtbb_port`

## Requirements
- R1: In any cycle after a clock edge with `rst` high, the drive registers hold test-clock 0, test-data-in 0 and test-mode-select 1. With `cable_sel` low, the chain pins show these values.
- R2: A write has `bus_strobe`, `bus_addr_valid` and `bus_wr` high and `bus_addr` equal to `PORT_ADDR`. It loads data bit 3 into test-data-in, bit 2 into test-mode-select and bit 1 into test-clock. All three change on the same clock edge. Data bits 7..4 and bit 0 are ignored.
- R3: The drive registers keep their value after any write cycle to another address, and after any write cycle with `bus_strobe` low or `bus_addr_valid` low.
- R4: A read has `bus_strobe` and `bus_addr_valid` high, `bus_wr` low and the decoded address. In that same cycle it drives `bus_rdata_oe` high. It returns on bit 0 the value `chain_tdo` had before the last two clock edges.
- R5: When `DIAG_READBACK` is 1, a read of the decoded address returns the registered test-data-in, test-mode-select and test-clock on bits 3, 2 and 1. Bits 7..4 read 0.
- R6: In any cycle that is not a read of the decoded address, `bus_rdata_oe` is low and `bus_rdata` is 0.
- R7: With `cable_sel` high, the chain pins follow `cable_tdi`, `cable_tms` and `cable_tck` in the same cycle. With `cable_sel` low, they show the drive registers. `cable_tdo` always follows `chain_tdo`.
- R8: Writes that land while `cable_sel` is high still update the drive registers. The new values reach the pins when `cable_sel` returns low.
- R9: A read of any address leaves the drive registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Processor address |
| bus_addr_valid | input | 1 | Address qualifier |
| bus_strobe | input | 1 | Data strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| bus_rdata_oe | output | 1 | Read data drive enable |
| cable_sel | input | 1 | 1 = cable header owns the chain pins |
| cable_tdi | input | 1 | Cable test-data-in |
| cable_tms | input | 1 | Cable test-mode-select |
| cable_tck | input | 1 | Cable test clock |
| cable_tdo | output | 1 | Chain test-data-out passed to the cable |
| chain_tdi | output | 1 | Chain test-data-in pin |
| chain_tms | output | 1 | Chain test-mode-select pin |
| chain_tck | output | 1 | Chain test-clock pin |
| chain_tdo | input | 1 | Chain test-data-out pin |

## Verification
Two functions can fall in the same cycle: a register write from the processor, and the cable override holding the chain pins. The bench raises `cable_sel` first and then writes a nibble. It checks that the pins stay on the cable inputs, that a readback already shows the new nibble, and that the nibble reaches the pins in the cycle `cable_sel` drops. A second overlap is a `chain_tdo` change made during a read. The bench judges it by the exact edge, two clocks later, at which bit 0 flips.

// File: rtl/jtbb_pkg.sv
package jtbb_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;

    localparam int BIT_TDI = 3;
    localparam int BIT_TMS = 2;
    localparam int BIT_TCK = 1;
    localparam int BIT_TDO = 0;

    typedef struct packed {
        logic tdi;
        logic tms;
        logic tck;
    } drive_t;

    localparam drive_t DRIVE_RESET = '{tdi: 1'b0, tms: 1'b1, tck: 1'b0};

    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } access_t;

    function automatic drive_t unpack_nibble(input logic [DATA_W-1:0] d);
        drive_t r;
        r.tdi = d[BIT_TDI];
        r.tms = d[BIT_TMS];
        r.tck = d[BIT_TCK];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_read(input drive_t dv, input logic tdo,
                                                    input logic diag);
        logic [DATA_W-1:0] r;
        r = '0;
        if (diag) begin
            r[BIT_TDI] = dv.tdi;
            r[BIT_TMS] = dv.tms;
            r[BIT_TCK] = dv.tck;
        end
        r[BIT_TDO] = tdo;
        return r;
    endfunction

endpackage

// File: rtl/jtbb_decode.sv
module jtbb_decode
    import jtbb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 20'hF0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    input  logic              strobe,
    input  logic              wr,
    output access_t           acc
);
    logic sel;

    always_comb begin
        sel        = addr_valid && strobe && (addr == PORT_ADDR);
        acc.wr_hit = sel && wr;
        acc.rd_hit = sel && !wr;
    end

endmodule

// File: rtl/jtbb_drive_regs.sv
module jtbb_drive_regs
    import jtbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output drive_t            drive_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            drive_q <= DRIVE_RESET;
        end else if (load) begin
            drive_q <= unpack_nibble(wdata);
        end
    end

    a_r1_reset_value: assert property (@(posedge clk)
        $past(rst) |-> drive_q == DRIVE_RESET);

    a_r3_hold_without_load: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(drive_q));

endmodule

// File: rtl/jtbb_tdo_sync.sv
module jtbb_tdo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

    a_r4_two_stage_delay: assert property (@(posedge clk) disable iff (rst)
        (STAGES == 2 && !$past(rst) && !$past(rst, 2)) |-> dout == $past(din, 2));

endmodule

// File: rtl/jtbb_pin_mux.sv
module jtbb_pin_mux
    import jtbb_pkg::*;
(
    input  logic   sel_cable,
    input  drive_t from_regs,
    input  drive_t from_cable,
    output drive_t to_pins
);
    always_comb begin
        to_pins = sel_cable ? from_cable : from_regs;
    end

endmodule

// File: rtl/jtbb_port.sv
module jtbb_port
    import jtbb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR     = 20'hF0000,
    parameter bit                DIAG_READBACK = 1'b1,
    parameter int                SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_addr_valid,
    input  logic              bus_strobe,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe,
    input  logic              cable_sel,
    input  logic              cable_tdi,
    input  logic              cable_tms,
    input  logic              cable_tck,
    output logic              cable_tdo,
    output logic              chain_tdi,
    output logic              chain_tms,
    output logic              chain_tck,
    input  logic              chain_tdo
);
    access_t acc;
    drive_t  drive_q;
    drive_t  cable_drv;
    drive_t  pin_drv;
    logic    tdo_sync;

    jtbb_decode #(.PORT_ADDR(PORT_ADDR)) i_decode (
        .addr       (bus_addr),
        .addr_valid (bus_addr_valid),
        .strobe     (bus_strobe),
        .wr         (bus_wr),
        .acc        (acc)
    );

    jtbb_drive_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (acc.wr_hit),
        .wdata   (bus_wdata),
        .drive_q (drive_q)
    );

    jtbb_tdo_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (chain_tdo),
        .dout (tdo_sync)
    );

    always_comb begin
        cable_drv.tdi = cable_tdi;
        cable_drv.tms = cable_tms;
        cable_drv.tck = cable_tck;
    end

    jtbb_pin_mux i_mux (
        .sel_cable  (cable_sel),
        .from_regs  (drive_q),
        .from_cable (cable_drv),
        .to_pins    (pin_drv)
    );

    assign chain_tdi = pin_drv.tdi;
    assign chain_tms = pin_drv.tms;
    assign chain_tck = pin_drv.tck;
    assign cable_tdo = chain_tdo;

    always_comb begin
        bus_rdata_oe = acc.rd_hit;
        bus_rdata    = acc.rd_hit ? pack_read(drive_q, tdo_sync, DIAG_READBACK) : '0;
    end

    a_r2_write_reaches_pins: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && bus_addr_valid && bus_wr && bus_addr == PORT_ADDR && !cable_sel)
        |=> (cable_sel || {chain_tdi, chain_tms, chain_tck} == $past(bus_wdata[3:1])));

    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !(bus_strobe && bus_addr_valid && !bus_wr && bus_addr == PORT_ADDR)
        |-> (!bus_rdata_oe && bus_rdata == '0));

    a_r9_read_keeps_regs: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_wr && !cable_sel) |=> $stable({chain_tdi, chain_tms, chain_tck}));

endmodule

// File: tb/test_jtbb_port.sv
module test_jtbb_port;
    import jtbb_pkg::*;

    localparam logic [ADDR_W-1:0] PADDR = 20'hF0000;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_addr_valid, bus_strobe, bus_wr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    logic              bus_rdata_oe;
    logic              cable_sel, cable_tdi, cable_tms, cable_tck, cable_tdo;
    logic              chain_tdi, chain_tms, chain_tck, chain_tdo;

    always #4 clk = ~clk;

    jtbb_port #(.PORT_ADDR(PADDR)) i_jtbb_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_addr_valid(bus_addr_valid),
        .bus_strobe(bus_strobe), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .cable_sel(cable_sel),
        .cable_tdi(cable_tdi), .cable_tms(cable_tms), .cable_tck(cable_tck),
        .cable_tdo(cable_tdo), .chain_tdi(chain_tdi), .chain_tms(chain_tms),
        .chain_tck(chain_tck), .chain_tdo(chain_tdo)
    );

    typedef struct {
        string      req;
        logic [2:0] pins;
        logic       check_bus;
        logic       oe;
        logic [7:0] data;
    } item_t;

    item_t q[$];
    event  ev_sample;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;

    initial begin : monitor
        forever begin
            @(ev_sample);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_cmp++;
                if ({chain_tdi, chain_tms, chain_tck} !== it.pins) begin
                    n_bad++;
                    $display("FAIL %s pins: actual %b expected %b", it.req,
                             {chain_tdi, chain_tms, chain_tck}, it.pins);
                end else if (it.check_bus && (bus_rdata_oe !== it.oe || bus_rdata !== it.data)) begin
                    n_bad++;
                    $display("FAIL %s bus: actual oe=%b data=%h expected oe=%b data=%h",
                             it.req, bus_rdata_oe, bus_rdata, it.oe, it.data);
                end
            end
        end
    end

    task automatic push(input string req, input logic [2:0] pins, input logic cb,
                        input logic oe, input logic [7:0] data);
        item_t it;
        it.req = req; it.pins = pins; it.check_bus = cb; it.oe = oe; it.data = data;
        #1;
        q.push_back(it);
        -> ev_sample;
        #1;
    endtask

    task automatic idle_bus();
        bus_strobe = 0; bus_addr_valid = 0; bus_wr = 0;
        bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                             input logic v, input logic s);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_addr_valid = v; bus_strobe = s; bus_wr = 1;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic set_read(input logic [ADDR_W-1:0] a);
        bus_addr = a; bus_addr_valid = 1; bus_strobe = 1; bus_wr = 0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        idle_bus();
        rst = 1; cable_sel = 0; cable_tdi = 0; cable_tms = 0; cable_tck = 0; chain_tdo = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        push("R1 reset pins", 3'b010, 0, 0, 8'h00);
        push("R6 idle bus quiet", 3'b010, 1, 0, 8'h00);

        set_read(PADDR);
        push("R5 reset readback", 3'b010, 1, 1, 8'h04);
        idle_bus();

        bus_write(PADDR, 8'h0A, 1, 1);
        push("R2 write tdi1 tms0 tck1", 3'b101, 0, 0, 8'h00);
        set_read(PADDR);
        push("R5 readback 0A", 3'b101, 1, 1, 8'h0A);
        idle_bus();

        bus_write(PADDR, 8'hF7, 1, 1);
        push("R2 upper and bit0 ignored", 3'b011, 0, 0, 8'h00);

        bus_write(PADDR ^ 20'h00001, 8'h08, 1, 1);
        push("R3 other address low bit", 3'b011, 0, 0, 8'h00);
        bus_write(PADDR ^ 20'h80000, 8'h08, 1, 1);
        push("R3 other address high bit", 3'b011, 0, 0, 8'h00);
        bus_write(PADDR, 8'h08, 0, 1);
        push("R3 no address valid", 3'b011, 0, 0, 8'h00);
        bus_write(PADDR, 8'h08, 1, 0);
        push("R3 no strobe", 3'b011, 0, 0, 8'h00);

        @(negedge clk);
        set_read(PADDR ^ 20'h00010);
        push("R6 read other address", 3'b011, 1, 0, 8'h00);
        @(negedge clk);
        idle_bus();
        push("R9 read leaves regs", 3'b011, 0, 0, 8'h00);

        @(negedge clk);
        chain_tdo = 1;
        set_read(PADDR);
        push("R4 tdo not yet synced", 3'b011, 1, 1, 8'h06);
        if (cable_tdo !== 1'b1) begin
            n_bad++; $display("FAIL R7 cable_tdo: actual %b expected 1", cable_tdo);
        end
        n_cmp++;
        @(negedge clk);
        push("R4 tdo after one edge", 3'b011, 1, 1, 8'h06);
        @(negedge clk);
        push("R4 tdo after two edges", 3'b011, 1, 1, 8'h07);
        idle_bus();
        push("R9 read left regs", 3'b011, 0, 0, 8'h00);

        @(negedge clk);
        cable_sel = 1; cable_tdi = 0; cable_tms = 0; cable_tck = 1;
        push("R7 cable owns pins", 3'b001, 0, 0, 8'h00);
        bus_write(PADDR, 8'h08, 1, 1);
        push("R8 write under cable pins stay", 3'b001, 0, 0, 8'h00);
        set_read(PADDR);
        push("R8 readback under cable", 3'b001, 1, 1, 8'h09);
        idle_bus();
        cable_tms = 1;
        push("R7 cable change follows", 3'b011, 0, 0, 8'h00);
        cable_sel = 0;
        push("R8 regs return to pins", 3'b100, 0, 0, 8'h00);

        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        push("R1 reset mid run", 3'b010, 0, 0, 8'h00);

        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule